// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the master side of a three-wire link to a small successive-approximation converter. The wires are an active-low chip select, a serial clock and a serial data input. A one-cycle start request lowers chip select. The block then holds a programmable setup interval, measured in system clocks. After that it sends a fixed burst of serial clocks, each made by dividing the system clock.

The converter launches one bit after every falling serial-clock edge. The controller samples each bit on the next rising edge. Each frame begins with four bits that must be zero, followed by the sample, MSB first. Once the frame closes, the controller raises chip select and presents the sample right-aligned with a one-cycle valid strobe. It also reports whether any of the leading positions carried a one. Chip select then stays high for a programmable minimum time before another request is accepted.

The resolution is an elaboration parameter of 12, 10 or 8 bits. It fixes the clock count per frame at 16, 14 or 12.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: While reset is asserted, cs_n and sclk are 1 and busy, data_valid, error and data_out are all 0.
- R2: A start pulse seen while busy is 0 makes cs_n 0 and busy 1 in the following cycle.
- R3: The first falling edge of sclk in a frame comes exactly SETUP_CYC system cycles after cs_n goes low.
- R4: Each frame carries RES+4 rising sclk edges (16, 14 or 12 for RES of 12, 10 or 8) between the fall and the rise of cs_n.
- R5: Within a frame, each sclk period is SCLK_HALF cycles low followed by SCLK_HALF cycles high. Between frames, sclk rests high.
- R6: sdi is sampled on each rising sclk edge, and the bits arrive MSB first. data_out holds the last RES bits received, right-aligned, and bits above RES are 0.
- R7: data_valid is high for exactly one cycle, namely the first cycle in which cs_n is high again after a frame. data_out holds its value until the next such cycle.
- R8: error is updated together with data_valid. It becomes 1 when any of the first four received bits of the frame was 1, becomes 0 otherwise, and holds between frames.
- R9: After each frame, cs_n stays high for at least GAP_CYC cycles. busy returns to 0 exactly GAP_CYC cycles after cs_n rises.
- R10: A start pulse that arrives while busy is 1 is ignored. No second frame starts, and exactly one data_valid is produced for the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request for a conversion frame |
| busy | output | 1 | High from the cycle after an accepted start until the gap interval ends |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter, idle high |
| sdi | input | 1 | Serial data from the converter |
| data_out | output | OUT_W | Last received sample, right-aligned |
| data_valid | output | 1 | One-cycle strobe marking a new sample |
| error | output | 1 | A leading bit of the last frame was 1 |

## Verification
Let t count cycles after the edge that accepts start. cs_n and busy change at t=1. sclk first falls at t=SETUP_CYC+1. sclk toggles every SCLK_HALF cycles for 2·SCLK_HALF·(RES+4) cycles. data_valid, the new data_out and the new error all appear together with the rise of cs_n. busy falls GAP_CYC cycles after that. A behavioural timeline in the bench predicts every output from t alone. It compares them on the falling system-clock edge, half a period after the registers settle. A bit-serving model answers each falling sclk edge, and lanes with different resolutions and dividers run side by side.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

   typedef enum logic [1:0] {
      RD_IDLE,
      RD_SETUP,
      RD_SHIFT,
      RD_GAP
   } rd_state_e;

   localparam int LEAD_ZEROS = 4;

   function automatic int frame_clocks(input int res);
      return res + LEAD_ZEROS;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rd_interval_timer.sv
module rd_interval_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R3
   timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/rd_sclk_gen.sv
module rd_sclk_gen #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sclk,
   output logic rise_tick,
   output logic period_end
);

   generate
      if (HALF < 1) begin : g_bad_half
         $error("rd_sclk_gen: HALF must be at least 1");
      end

      if (HALF == 1) begin : g_toggle
         logic hi_phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hi_phase <= 1'b0;
            else if (!en)
               hi_phase <= 1'b0;
            else
               hi_phase <= ~hi_phase;
         end
         assign sclk       = ~(en & ~hi_phase);
         assign rise_tick  = en & ~hi_phase;
         assign period_end = en & hi_phase;
      end else begin : g_count
         localparam int PER = 2 * HALF;
         localparam int PW  = $clog2(PER);
         logic [PW-1:0] ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ph <= '0;
            else if (!en)
               ph <= '0;
            else if (ph == PW'(PER - 1))
               ph <= '0;
            else
               ph <= ph + 1'b1;
         end
         assign sclk       = ~(en & (ph < PW'(HALF)));
         assign rise_tick  = en & (ph == PW'(HALF - 1));
         assign period_end = en & (ph == PW'(PER - 1));
      end
   endgenerate

   // R5
   rise_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_tick |=> sclk);

   // R5
   period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> (sclk == !en));

endmodule

// File: rtl/rd_shift_capture.sv
module rd_shift_capture #(
   parameter int FRAME = 16,
   parameter int RES   = 12,
   parameter int OUT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample,
   input  logic             sdi,
   input  logic             commit,
   output logic [OUT_W-1:0] data_out,
   output logic             valid,
   output logic             lead_err
);

   logic [FRAME-1:0] shreg;
   logic [OUT_W-1:0] padded;

   generate
      if (FRAME <= RES) begin : g_bad_frame
         $error("rd_shift_capture: FRAME must exceed RES");
      end
      if (OUT_W > RES) begin : g_pad
         assign padded = {{(OUT_W - RES){1'b0}}, shreg[RES-1:0]};
      end else begin : g_exact
         assign padded = shreg[OUT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shreg <= '0;
      else if (sample)
         shreg <= {shreg[FRAME-2:0], sdi};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out <= '0;
         lead_err <= 1'b0;
         valid    <= 1'b0;
      end else begin
         valid <= commit;
         if (commit) begin
            data_out <= padded;
            lead_err <= |shreg[FRAME-1:RES];
         end
      end
   end

   // R7
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R8
   err_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lead_err) |-> valid);

   // R7
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_out) |-> valid);

endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
   import adc_rdout_pkg::*;
#(
   parameter int RES       = 12,
   parameter int OUT_W     = 12,
   parameter int SCLK_HALF = 2,
   parameter int SETUP_CYC = 3,
   parameter int GAP_CYC   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             cs_n,
   output logic             sclk,
   input  logic             sdi,
   output logic [OUT_W-1:0] data_out,
   output logic             data_valid,
   output logic             error
);

   localparam int FRAME = frame_clocks(RES);
   localparam int BW    = $clog2(FRAME);
   localparam int TMAX  = max2(SETUP_CYC, GAP_CYC);
   localparam int TW    = $clog2(TMAX + 1);

   generate
      if (!(RES == 8 || RES == 10 || RES == 12)) begin : g_bad_res
         $error("adc_rdout_ctrl: RES must be 8, 10 or 12");
      end
      if (OUT_W < RES) begin : g_bad_outw
         $error("adc_rdout_ctrl: OUT_W must be at least RES");
      end
      if (SETUP_CYC < 1 || GAP_CYC < 1) begin : g_bad_timing
         $error("adc_rdout_ctrl: SETUP_CYC and GAP_CYC must be at least 1");
      end
   endgenerate

   rd_state_e      state, state_nx;
   logic [BW-1:0]  bitcnt;
   logic           shift_en, rise_tick, period_end, last_end;
   logic           t_load, t_expired;
   logic [TW-1:0]  t_val;
   logic           accept;

   assign accept   = (state == RD_IDLE) && start;
   assign shift_en = (state == RD_SHIFT);
   assign last_end = shift_en && period_end && (bitcnt == BW'(FRAME - 1));
   assign t_load   = accept || last_end;
   assign t_val    = accept ? TW'(SETUP_CYC - 1) : TW'(GAP_CYC - 1);

   always_comb begin
      state_nx = state;
      unique case (state)
         RD_IDLE:  if (start)     state_nx = RD_SETUP;
         RD_SETUP: if (t_expired) state_nx = RD_SHIFT;
         RD_SHIFT: if (last_end)  state_nx = RD_GAP;
         RD_GAP:   if (t_expired) state_nx = RD_IDLE;
         default:                 state_nx = RD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= RD_IDLE;
      else
         state <= state_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bitcnt <= '0;
      else if (!shift_en)
         bitcnt <= '0;
      else if (period_end)
         bitcnt <= bitcnt + 1'b1;
   end

   assign busy = (state != RD_IDLE);
   assign cs_n = !((state == RD_SETUP) || (state == RD_SHIFT));

   rd_interval_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_expired)
   );

   rd_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (shift_en),
      .sclk       (sclk),
      .rise_tick  (rise_tick),
      .period_end (period_end)
   );

   rd_shift_capture #(.FRAME(FRAME), .RES(RES), .OUT_W(OUT_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample   (rise_tick),
      .sdi      (sdi),
      .commit   (last_end),
      .data_out (data_out),
      .valid    (data_valid),
      .lead_err (error)
   );

   // ---------------- protocol checks ----------------
   localparam int LW = $clog2(SETUP_CYC + 2);
   localparam int HW = $clog2(GAP_CYC + 1);

   logic          sclk_q;
   logic [BW:0]   rise_cnt;
   logic [LW-1:0] low_cnt;
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b1;
         rise_cnt <= '0;
         low_cnt  <= '0;
         hi_cnt   <= HW'(GAP_CYC);
      end else begin
         sclk_q <= sclk;
         if (cs_n) begin
            rise_cnt <= '0;
            low_cnt  <= '0;
            if (hi_cnt != HW'(GAP_CYC))
               hi_cnt <= hi_cnt + 1'b1;
         end else begin
            hi_cnt <= '0;
            if (sclk && !sclk_q)
               rise_cnt <= rise_cnt + 1'b1;
            if (low_cnt != LW'(SETUP_CYC + 1))
               low_cnt <= low_cnt + 1'b1;
         end
      end
   end

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (!cs_n && busy));

   // R10
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && cs_n) |=> cs_n);

   // R3
   setup_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && sclk_q && !sclk && rise_cnt == '0) |-> (low_cnt == LW'(SETUP_CYC)));

   // R4
   frame_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (rise_cnt == (BW+1)'(FRAME)));

   // R9
   gap_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (hi_cnt >= HW'(GAP_CYC)));

   // R7
   valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (cs_n && $past(!cs_n)));

   // R5
   idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

endmodule

// File: tb/tb_adc_rdout_ctrl.sv
module tb_adc_rdout_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int SET = 3;
   localparam int GAP = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   total = 0;
   int   bad = 0;
   int   lanes_done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int lane, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s lane=%0d act=%0d exp=%0d t=%0t", tag, lane, act, exp, $time);
      end
   endtask

   for (genvar g = 0; g < 3; g++) begin : ln
      localparam int R   = 12 - 2 * g;
      localparam int F   = R + 4;
      localparam int D   = g + 1;
      localparam int XF  = F * 2 * D;
      localparam int TOT = SET + XF + GAP;

      logic        start = 1'b0;
      logic        sdi = 1'b0;
      logic        busy, cs_n, sclk, dv, err;
      logic [11:0] dout;
      logic [15:0] fbits = '0;
      int          exp_word = 0;
      int          exp_err = 0;
      int          t = 0;
      int          k = 0;
      int          dvc = 0;
      int          rises = 0, lowc = 0, hic = 0, frames = 0;
      logic        pcs = 1'b1, psclk = 1'b1;

      adc_rdout_ctrl #(.RES(R), .OUT_W(12), .SCLK_HALF(D), .SETUP_CYC(SET), .GAP_CYC(GAP)) dut (
         .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cs_n(cs_n), .sclk(sclk),
         .sdi(sdi), .data_out(dout), .data_valid(dv), .error(err)
      );

      // converter model: next bit after every falling sclk edge
      always @(negedge cs_n) k = 0;
      always @(negedge sclk) if (!cs_n && k < F) begin
         sdi <= fbits[F-1-k];
         k = k + 1;
      end
      always @(posedge cs_n) sdi <= 1'b0;

      // reference timeline
      always @(posedge clk) begin
         if (!rst_n) t <= 0;
         else if (t == 0) begin
            if (start) t <= 1;
         end else if (t == TOT) t <= 0;
         else t <= t + 1;
         if (rst_n && dv) dvc <= dvc + 1;
      end

      always @(negedge clk) if (rst_n) begin
         bit e_cs, e_busy, e_sclk, e_dv, in_x;
         e_cs   = !(t >= 1 && t <= SET + XF);
         e_busy = (t != 0);
         in_x   = (t > SET && t <= SET + XF);
         e_sclk = !(in_x && (((t - SET - 1) % (2 * D)) < D));
         e_dv   = (t == SET + XF + 1);
         chk(cs_n == e_cs, "R2", g, cs_n, e_cs);
         chk(busy == e_busy, "R9", g, busy, e_busy);
         chk(sclk == e_sclk, "R5", g, sclk, e_sclk);
         chk(dv == e_dv, "R7", g, dv, e_dv);
         if (e_dv) begin
            chk(dout == 12'(exp_word), "R6", g, dout, exp_word);
            chk(int'(err) == exp_err, "R8", g, err, exp_err);
         end
         // independent monitors on the pins
         if (!cs_n) begin
            if (pcs && frames > 0) chk(hic >= GAP, "R9", g, hic, GAP);
            if (!sclk && psclk && rises == 0) chk(lowc == SET, "R3", g, lowc, SET);
            if (sclk && !psclk) rises++;
            lowc++;
            hic = 0;
         end else begin
            if (!pcs) begin
               chk(rises == F, "R4", g, rises, F);
               frames++;
            end
            rises = 0;
            lowc = 0;
            hic++;
         end
         pcs = cs_n;
         psclk = sclk;
      end

      task automatic run(input int w, input int lz, input int extra_at);
         fbits    = (16'(lz) << R) | 16'(w & ((1 << R) - 1));
         exp_word = w & ((1 << R) - 1);
         exp_err  = (lz != 0) ? 1 : 0;
         dvc = 0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         if (extra_at > 0) begin
            while (t != extra_at) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
         while (t != 0) @(negedge clk);
         // R10: one strobe per accepted frame, extra request dropped
         chk(dvc == 1, "R10", g, dvc, 1);
         chk(int'(err) == exp_err, "R8", g, err, exp_err);
         chk(dout == 12'(exp_word), "R7", g, dout, exp_word);
      endtask

      initial begin
         @(negedge clk);
         chk(cs_n && sclk && !busy && !dv && !err && dout == 0, "R1", g,
             {cs_n, sclk, busy, dv, err}, 5'b11000);
         wait (rst_n);
         @(negedge clk);
         run(12'hA5C, 0, 0);
         repeat (3) @(negedge clk);
         run(12'hFFF, 0, SET + 4);
         run(12'h001, 4'b1000, 0);
         repeat (2) @(negedge clk);
         run(12'h3C3, 0, SET + XF + 2);
         run(12'h000, 4'b0001, TOT);
         run(12'h800, 0, 0);
         repeat (4) @(negedge clk);
         lanes_done++;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      fork
         wait (lanes_done == 3);
         begin
            repeat (100000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog lanes_done=%0d exp=3", lanes_done);
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule